// File: doc/BRIEF.md
# Single-Wire Transaction Responder

This block is the answering end of a half-duplex link that shares one open-drain wire between an initiator and a target. The wire idles released and is pulled high. The initiator opens an exchange by pulling the wire low and then sends a one-byte header. The header carries a table index and a small check field.

When the header is valid, the target answers with a timed handshake. It then streams out the response bytes stored for that index, hands the wire back with a turnaround pulse, and takes in the request bytes. At the end it records a per-index outcome. An invalid header is dropped without any reply, so the initiator sees a missing target.

Every byte on the wire, in either direction, uses the same frame, each slot lasting `BIT_CYC` clocks:
- a low sync slot;
- one high mark slot;
- eight data slots, most significant bit first;
- an even-parity slot;
- then the wire is held low.

A small register table holds, per index, a response length, a request length, a response buffer, a request buffer and a 2-bit outcome. The outcome is cleared when it is read.

Top module: `sw_target_responder`

## Requirements
- R1: After reset and whenever no exchange is in progress, `line_oe` is 0 and every outcome entry reads 00. The block first drives the wire with the acknowledge high pulse.
- R2: While idle, a low level on `line_in` starts reception of a header. The header is one frame: low sync, rising edge, one high mark slot, eight data slots MSB first, then a parity slot equal to the XOR of the eight data bits. Each slot is `BIT_CYC` clocks. The target samples each slot near its middle.
- R3: The header holds the index in bits 7:3 and, in bits 2:0, the number of ones in bits 6:3 (the index's low four bits). The header is dropped and the block returns to idle without ever driving the wire, and with all outcomes unchanged, if any of these holds:
  - the check field is wrong;
  - the parity is wrong;
  - the index is not below `N_IDX`.
- R4: For an accepted header, the block keeps the wire released for half a slot. It then drives the wire high for exactly `ACK_CYC` clocks and then drives it low.
- R5: If the response length of the index is nonzero, that many bytes are sent from the response buffer, position 0 first. Each byte uses the R2 frame with even parity. The wire stays low between bytes.
- R6: The turnaround is driven low for one slot, then driven high for exactly `BIT_CYC/2` clocks, then released. It stays released for half a slot before the block listens.
- R7: The block receives as many request bytes as the index's request length and stores every one in the request buffer in arrival order. The outcome becomes 01 (accepted) if all of them have correct parity, and 10 (data error) otherwise. A zero request length gives 01.
- R8: After the last request byte, the block keeps the wire released for as long as the initiator holds it low. It returns to idle only after the wire goes high.
- R9: `stat_out` shows the outcome of entry `stat_idx`. A one-clock `stat_clr` sets that entry to 00 and leaves the other entries alone. A write from a finishing exchange in the same clock takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_in | input | 1 | Sampled level of the shared wire |
| line_oe | output | 1 | Target drives the wire when 1 |
| line_out | output | 1 | Level driven when `line_oe` is 1 |
| cfg_we | input | 1 | Write lengths of entry `cfg_idx` |
| cfg_idx | input | $clog2(N_IDX) | Entry for length write |
| cfg_tx_len | input | $clog2(MAXB+1) | Response byte count |
| cfg_rx_len | input | $clog2(MAXB+1) | Request byte count |
| buf_we | input | 1 | Write one response-buffer byte |
| buf_idx | input | $clog2(N_IDX) | Entry for buffer access |
| buf_pos | input | $clog2(MAXB) | Byte position for buffer access |
| buf_wdata | input | 8 | Response byte to store |
| rx_rdata | output | 8 | Request-buffer byte at `buf_idx`/`buf_pos` |
| stat_idx | input | $clog2(N_IDX) | Entry whose outcome is shown |
| stat_clr | input | 1 | Clear outcome of `stat_idx` |
| stat_out | output | 2 | Outcome: 00 none, 01 accepted, 10 data error |

## Verification
The bench builds the block with four table entries, up to four bytes each way, 16-clock slots and an 8-clock acknowledge. These values keep every one of the 256 possible header bytes within reach of a single sweep: wrong check fields, indices 4 to 31, and all four well-formed headers sent with inverted parity. The same values allow a full cross of response and request lengths from 0 to 4, with byte values and the parity of each received bit computed arithmetically. Slot widths are small enough that the exact acknowledge and turnaround pulse widths are counted clock by clock.

// File: rtl/sw_target_responder.sv
module sw_target_responder #(
  parameter int N_IDX     = 4,
  parameter int MAXB      = 4,
  parameter int BIT_CYC   = 16,
  parameter int ACK_CYC   = 8,
  parameter int SYNC_WAIT = 5
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        line_in,
  output logic                        line_oe,
  output logic                        line_out,
  input  logic                        cfg_we,
  input  logic [$clog2(N_IDX)-1:0]    cfg_idx,
  input  logic [$clog2(MAXB+1)-1:0]   cfg_tx_len,
  input  logic [$clog2(MAXB+1)-1:0]   cfg_rx_len,
  input  logic                        buf_we,
  input  logic [$clog2(N_IDX)-1:0]    buf_idx,
  input  logic [$clog2(MAXB)-1:0]     buf_pos,
  input  logic [7:0]                  buf_wdata,
  output logic [7:0]                  rx_rdata,
  input  logic [$clog2(N_IDX)-1:0]    stat_idx,
  input  logic                        stat_clr,
  output logic [1:0]                  stat_out
);
  localparam int IW   = $clog2(N_IDX);
  localparam int PW   = $clog2(MAXB);
  localparam int LW   = $clog2(MAXB+1);
  localparam int HALF = BIT_CYC / 2;
  localparam int TMO  = SYNC_WAIT * BIT_CYC;
  localparam int CW   = $clog2(TMO + BIT_CYC + ACK_CYC + 1);
  localparam logic [CW-1:0] C_BIT  = CW'(BIT_CYC - 1);
  localparam logic [CW-1:0] C_HALF = CW'(HALF - 1);
  localparam logic [CW-1:0] C_ACK  = CW'(ACK_CYC - 1);
  localparam logic [CW-1:0] C_TMO  = CW'(TMO - 1);

  typedef enum logic [3:0] {
    S_IDLE, S_RHI, S_RLO, S_RBITS, S_HALF, S_ACKH, S_TX, S_TAL, S_TAH, S_TAR
  } st_t;
  typedef enum logic [1:0] {PH_HDR, PH_DATA, PH_FIN} ph_t;

  st_t            st;
  ph_t            ph;
  logic           ln_r;
  logic [CW-1:0]  sub;
  logic [3:0]     slot;
  logic [LW-1:0]  bcnt;
  logic [8:0]     sh;
  logic           err;
  logic [IW-1:0]  cur;

  logic [7:0]     tx_mem [N_IDX][MAXB];
  logic [7:0]     rx_mem [N_IDX][MAXB];
  logic [LW-1:0]  txl    [N_IDX];
  logic [LW-1:0]  rxl    [N_IDX];
  logic [1:0]     stat   [N_IDX];

  logic [7:0] rbyte, txb;
  logic [4:0] hid;
  logic [2:0] pc;
  logic       rpar_ok, hdr_ok, done_byte, rx_we, last_rx, last_tx;
  logic       stat_we, tbit;
  logic [1:0] stat_wv;

  assign rbyte     = sh[8:1];
  assign rpar_ok   = (^rbyte) == sh[0];
  assign hid       = rbyte[7:3];
  assign pc        = 3'(hid[0]) + 3'(hid[1]) + 3'(hid[2]) + 3'(hid[3]);
  assign hdr_ok    = rpar_ok && (rbyte[2:0] == pc) && (int'(hid) < N_IDX);
  assign done_byte = (st == S_RBITS) && (sub == C_BIT) && (slot == 4'd9);
  assign rx_we     = done_byte && (ph == PH_DATA);
  assign last_rx   = (bcnt + LW'(1)) == rxl[cur];
  assign last_tx   = (bcnt + LW'(1)) == txl[cur];
  assign stat_we   = (rx_we && last_rx) ||
                     ((st == S_TAR) && (sub == C_HALF) && (rxl[cur] == '0));
  assign stat_wv   = ((st == S_RBITS) && (err || !rpar_ok)) ? 2'b10 : 2'b01;
  assign txb       = tx_mem[cur][bcnt[PW-1:0]];
  assign rx_rdata  = rx_mem[buf_idx][buf_pos];
  assign stat_out  = stat[stat_idx];

  always_comb begin
    case (slot)
      4'd0:    tbit = 1'b0;
      4'd1:    tbit = 1'b1;
      4'd10:   tbit = ^txb;
      default: tbit = txb[3'(4'd9 - slot)];
    endcase
  end

  assign line_oe  = (st == S_ACKH) || (st == S_TX) || (st == S_TAL) || (st == S_TAH);
  assign line_out = (st == S_ACKH) || (st == S_TAH) || ((st == S_TX) && tbit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      ph   <= PH_HDR;
      ln_r <= 1'b1;
      sub  <= '0;
      slot <= '0;
      bcnt <= '0;
      sh   <= '0;
      err  <= 1'b0;
      cur  <= '0;
    end else begin
      ln_r <= line_in;
      case (st)
        S_IDLE: begin
          sub <= '0;
          if (!ln_r) begin
            st <= S_RLO;
            ph <= PH_HDR;
          end
        end
        S_RHI:
          if (!ln_r || sub == C_TMO) begin
            st  <= S_RLO;
            sub <= '0;
          end else sub <= sub + CW'(1);
        S_RLO:
          if (ln_r) begin
            if (ph == PH_FIN) st <= S_IDLE;
            else begin
              st   <= S_RBITS;
              sub  <= '0;
              slot <= '0;
            end
          end
        S_RBITS: begin
          if (sub == C_HALF && slot != 4'd0) sh <= {sh[7:0], ln_r};
          if (sub == C_BIT) begin
            sub <= '0;
            if (slot != 4'd9) slot <= slot + 4'd1;
            else if (ph == PH_HDR) begin
              if (hdr_ok) begin
                cur <= hid[IW-1:0];
                st  <= S_HALF;
              end else st <= S_IDLE;
            end else begin
              err  <= err | !rpar_ok;
              bcnt <= bcnt + LW'(1);
              if (last_rx) ph <= PH_FIN;
              st <= S_RHI;
            end
          end else sub <= sub + CW'(1);
        end
        S_HALF:
          if (sub == C_HALF) begin
            sub <= '0;
            st  <= S_ACKH;
          end else sub <= sub + CW'(1);
        S_ACKH:
          if (sub == C_ACK) begin
            sub  <= '0;
            slot <= '0;
            bcnt <= '0;
            st   <= (txl[cur] != '0) ? S_TX : S_TAL;
          end else sub <= sub + CW'(1);
        S_TX:
          if (sub == C_BIT) begin
            sub <= '0;
            if (slot == 4'd10) begin
              slot <= '0;
              bcnt <= bcnt + LW'(1);
              if (last_tx) st <= S_TAL;
            end else slot <= slot + 4'd1;
          end else sub <= sub + CW'(1);
        S_TAL:
          if (sub == C_BIT) begin
            sub <= '0;
            st  <= S_TAH;
          end else sub <= sub + CW'(1);
        S_TAH:
          if (sub == C_HALF) begin
            sub <= '0;
            st  <= S_TAR;
          end else sub <= sub + CW'(1);
        S_TAR:
          if (sub == C_HALF) begin
            sub  <= '0;
            bcnt <= '0;
            err  <= 1'b0;
            ph   <= (rxl[cur] != '0) ? PH_DATA : PH_FIN;
            st   <= S_RHI;
          end else sub <= sub + CW'(1);
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_IDX; i++) begin
        txl[i]  <= '0;
        rxl[i]  <= '0;
        stat[i] <= 2'b00;
      end
    end else begin
      if (cfg_we) begin
        txl[cfg_idx] <= cfg_tx_len;
        rxl[cfg_idx] <= cfg_rx_len;
      end
      if (stat_clr) stat[stat_idx] <= 2'b00;
      if (stat_we)  stat[cur]      <= stat_wv;
    end
  end

  always_ff @(posedge clk) begin
    if (buf_we) tx_mem[buf_idx][buf_pos] <= buf_wdata;
    if (rx_we)  rx_mem[cur][bcnt[PW-1:0]] <= rbyte;
  end

  assert_drive_starts_at_ack_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(line_oe) |-> $past(st) == S_HALF);

  assert_reject_goes_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (done_byte && ph == PH_HDR && !hdr_ok) |=> (st == S_IDLE && !line_oe));

  assert_ack_falls_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st) == S_ACKH && st != S_ACKH) |-> (line_oe && !line_out && $past(line_out)));

  assert_len_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |-> (int'(cfg_tx_len) <= MAXB && int'(cfg_rx_len) <= MAXB));

  assert_turnaround_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_TAR && $past(st) == S_TAH) |-> (!line_oe && $past(line_oe && line_out)));

  assert_outcome_recorded_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stat_we |=> stat[$past(cur)] != 2'b00);

  assert_read_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_clr && !(stat_we && cur == stat_idx)) |=> stat[$past(stat_idx)] == 2'b00);
endmodule

// File: tb/tb_sw_target_responder.sv
module tb_sw_target_responder;
  localparam int N    = 4;
  localparam int MAXB = 4;
  localparam int BIT  = 16;
  localparam int ACK  = 8;
  localparam int HALF = BIT / 2;
  localparam int IW   = $clog2(N);
  localparam int PW   = $clog2(MAXB);
  localparam int LW   = $clog2(MAXB+1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic i_oe = 1'b0, i_out = 1'b0;
  logic lvl, line_oe, line_out;
  logic cfg_we = 1'b0, buf_we = 1'b0, stat_clr = 1'b0;
  logic [IW-1:0] cfg_idx = '0, buf_idx = '0, stat_idx = '0;
  logic [LW-1:0] cfg_tx_len = '0, cfg_rx_len = '0;
  logic [PW-1:0] buf_pos = '0;
  logic [7:0] buf_wdata = '0, rx_rdata;
  logic [1:0] stat_out;
  int nchk = 0, nfail = 0, contention = 0;

  always #4 clk = ~clk;
  assign lvl = line_oe ? line_out : (i_oe ? i_out : 1'b1);

  sw_target_responder #(.N_IDX(N), .MAXB(MAXB), .BIT_CYC(BIT), .ACK_CYC(ACK)) dut (
    .clk(clk), .rst_n(rst_n), .line_in(lvl), .line_oe(line_oe), .line_out(line_out),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_tx_len(cfg_tx_len), .cfg_rx_len(cfg_rx_len),
    .buf_we(buf_we), .buf_idx(buf_idx), .buf_pos(buf_pos), .buf_wdata(buf_wdata),
    .rx_rdata(rx_rdata), .stat_idx(stat_idx), .stat_clr(stat_clr), .stat_out(stat_out));

  always @(negedge clk) if (rst_n && line_oe && i_oe) contention++;

  task automatic tick(input int n); repeat (n) @(negedge clk); endtask

  task automatic chk_eq(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
  endtask

  function automatic int pc4(input int v);
    return (v & 1) + ((v >> 1) & 1) + ((v >> 2) & 1) + ((v >> 3) & 1);
  endfunction
  function automatic int txd(input int idx, input int p, input int tl);
    return (idx * 53 + p * 29 + tl * 7 + 1) % 256;
  endfunction
  function automatic int rxd(input int idx, input int p, input int rl);
    return (idx * 11 + p * 97 + rl * 13 + 200) % 256;
  endfunction

  task automatic send_byte(input logic [7:0] b, input bit badpar);
    i_oe = 1'b1; i_out = 1'b0; tick(BIT);
    i_out = 1'b1; tick(BIT);
    for (int k = 7; k >= 0; k--) begin i_out = b[k]; tick(BIT); end
    i_out = (^b) ^ badpar; tick(BIT);
    i_out = 1'b0;
  endtask

  task automatic send_hdr(input logic [7:0] h, input bit badpar);
    i_oe = 1'b1; i_out = 1'b0; tick(BIT);
    send_byte(h, badpar);
    i_oe = 1'b0;
  endtask

  task automatic recv_byte(output logic [7:0] b, output logic p);
    int cnt;
    cnt = 0; while (lvl == 1'b1 && cnt < 6*BIT) begin tick(1); cnt++; end
    cnt = 0; while (lvl == 1'b0 && cnt < 3*BIT) begin tick(1); cnt++; end
    tick(BIT + HALF); b[7] = lvl;
    for (int k = 6; k >= 0; k--) begin tick(BIT); b[k] = lvl; end
    tick(BIT); p = lvl;
    tick(HALF);
  endtask

  task automatic run_txn(input int idx, input int tl, input int rl, input int bad,
                         input int hold, input bit clr);
    int cnt; bit saw; logic [7:0] b; logic p;
    cfg_we = 1'b1; cfg_idx = IW'(idx); cfg_tx_len = LW'(tl); cfg_rx_len = LW'(rl);
    tick(1); cfg_we = 1'b0;
    for (int q = 0; q < tl; q++) begin
      buf_we = 1'b1; buf_idx = IW'(idx); buf_pos = PW'(q); buf_wdata = 8'(txd(idx, q, tl));
      tick(1);
    end
    buf_we = 1'b0;
    send_hdr(8'((idx << 3) | pc4(idx)), 1'b0);
    cnt = 0; while (!line_oe && cnt < 4*BIT) begin tick(1); cnt++; end
    chk_eq("R2 header accepted, ack begins", int'(line_oe), 1);
    cnt = 0; while (line_oe && line_out && cnt < 4*ACK) begin tick(1); cnt++; end
    chk_eq("R4 ack high width", cnt, ACK);
    chk_eq("R4 ack ends driven low", int'(line_oe && !line_out), 1);
    for (int q = 0; q < tl; q++) begin
      recv_byte(b, p);
      chk_eq("R5 response byte", int'(b), txd(idx, q, tl));
      chk_eq("R5 response parity", int'(p), int'(^b));
    end
    cnt = 0; while (lvl == 1'b0 && cnt < 4*BIT) begin tick(1); cnt++; end
    cnt = 0; while (line_oe && line_out && cnt < 4*BIT) begin tick(1); cnt++; end
    chk_eq("R6 turnaround high width", cnt, HALF);
    chk_eq("R6 turnaround releases", int'(line_oe), 0);
    tick(BIT);
    i_oe = 1'b1; i_out = 1'b0;
    for (int q = 0; q < rl; q++) send_byte(8'(rxd(idx, q, rl)), q == bad);
    saw = 1'b0;
    for (int c = 0; c < hold; c++) begin tick(1); if (line_oe) saw = 1'b1; end
    chk_eq("R8 released while initiator holds low", int'(saw), 0);
    i_oe = 1'b0; tick(4);
    stat_idx = IW'(idx); #1;
    chk_eq("R7 outcome", int'(stat_out), (bad >= 0 && bad < rl) ? 2 : 1);
    for (int q = 0; q < rl; q++) begin
      buf_idx = IW'(idx); buf_pos = PW'(q); #1;
      chk_eq("R7 request byte stored", int'(rx_rdata), rxd(idx, q, rl));
    end
    if (clr) begin
      tick(1); stat_clr = 1'b1; tick(1); stat_clr = 1'b0; #1;
      chk_eq("R9 outcome cleared by read", int'(stat_out), 0);
    end
    tick(2);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog R1 actual=running expected=finished");
    report;
    $finish;
  end

  initial begin
    bit saw, valid;
    tick(5); rst_n = 1'b1; tick(2);
    chk_eq("R1 released after reset", int'(line_oe), 0);
    for (int i = 0; i < N; i++) begin
      stat_idx = IW'(i); #1;
      chk_eq("R1 outcome empty after reset", int'(stat_out), 0);
    end

    for (int hb = 0; hb < 256; hb++) begin
      valid = ((hb >> 3) < N) && ((hb & 7) == pc4(hb >> 3));
      send_hdr(8'(hb), valid);
      saw = 1'b0;
      for (int c = 0; c < 4*BIT; c++) begin tick(1); if (line_oe) saw = 1'b1; end
      chk_eq($sformatf("R3 header %0d ignored", hb), int'(saw), 0);
    end
    for (int i = 0; i < N; i++) begin
      stat_idx = IW'(i); #1;
      chk_eq("R3 outcomes untouched by rejects", int'(stat_out), 0);
    end

    for (int tl = 0; tl <= MAXB; tl++)
      for (int rl = 0; rl <= MAXB; rl++)
        run_txn((tl * 5 + rl) % N, tl, rl, -1, BIT, 1'b1);

    run_txn(2, 1, 3, 1, BIT, 1'b1);
    run_txn(3, 0, 2, 1, BIT, 1'b1);
    run_txn(1, 2, 1, -1, 6*BIT, 1'b1);
    run_txn(0, 1, 1, -1, BIT, 1'b1);

    run_txn(0, 1, 1, -1, BIT, 1'b0);
    run_txn(1, 0, 0, -1, BIT, 1'b0);
    stat_idx = IW'(1); #1;
    chk_eq("R9 entry 1 holds before clear", int'(stat_out), 1);
    tick(1); stat_idx = IW'(0); stat_clr = 1'b1; tick(1); stat_clr = 1'b0; #1;
    chk_eq("R9 entry 0 cleared", int'(stat_out), 0);
    stat_idx = IW'(1); #1;
    chk_eq("R9 entry 1 kept", int'(stat_out), 1);

    chk_eq("R6 no wire contention", contention, 0);
    report;
    $finish;
  end
endmodule